// File: doc/BRIEF.md
# Programmable Memory Region Address Decoder

The decoder turns a CPU bus address into a one-hot select for one of four memory regions: ROM, program flash, data flash and RAM. Each region has its own configuration word, written by software in a single access. The word holds a page-aligned base, a power-of-two size code and a write-protect flag. The ROM region's word also carries the global map-enable bit. Until that bit is set, every access goes to the ROM. Boot code can therefore run before the map is set up.

Regions can be moved at run time and may overlap. A typical boot sequence works like this. The ROM first opens a 64 KB window over the whole low space. The smaller windows placed inside it win over it. Later the ROM is shrunk to a 4 KB window and program flash is moved to address zero. An address that hits no enabled region raises a decode-miss output. A write that lands in a write-protected region produces a one-cycle fault pulse, which the system uses to request a CPU reset.

Top module: `mem_region_decoder`

## Requirements
- R1: While the map-enable bit is clear (the state after reset), every strobed access asserts only the ROM select (`sel_o` = 4'b0001), never `miss_o`, and never `fault_o`, including for writes.
- R2: A region spans 512 << size code bytes (code 2 is 2 KB, code 3 is 4 KB, code 6 is 32 KB, code 7 is 64 KB). An address hits the region when it equals the base after the low 9 + code bits of both are cleared. The base address is the page field times 1 KB.
- R3: A configuration word has the page field in bits [6:0] (address bits [16:10]), the size code in bits [10:8], the write-protect flag in bit 12 and map enable in bit 15. `cfg_idx_i` selects the region: 0 ROM, 1 program flash, 2 data flash, 3 RAM. A write is visible to accesses from the next clock cycle on.
- R4: When regions overlap, priority is RAM, then data flash, then program flash, then ROM. Only the winner's select is asserted, so `sel_o` is one-hot or zero.
- R5: With the map enabled, a strobed address that hits no region asserts `miss_o` and leaves `sel_o` zero. A hit never asserts `miss_o`.
- R6: With the map enabled, a strobed write whose winning region has the write-protect flag set asserts `fault_o` for exactly the one cycle after the strobe.
- R7: A read from a write-protected region gives no fault. A write to a non-protected region gives no fault, even where that region lies inside a protected ROM window. A write that misses gives no fault.
- R8: Without `acc_valid_i`, `sel_o` is zero and `miss_o` is low.
- R9: Only region 0 controls map enable. Bit 15 in the words of regions 1 to 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_idx_i | input | 2 | Region index of the write |
| cfg_wdata_i | input | 16 | Packed configuration word |
| acc_valid_i | input | 1 | Bus access strobe |
| acc_we_i | input | 1 | Access is a write |
| addr_i | input | 17 | Byte address of the access |
| sel_o | output | 4 | One-hot region select, bit n = region n |
| miss_o | output | 1 | Enabled map and no region hit |
| fault_o | output | 1 | Registered write-protect violation pulse |

## Verification
The hardest situations to reach from the ports are layered overlaps. One is a write into a non-protected window nested inside a protected ROM window, which must give no fault. Another is an address just past a small region that still falls inside a larger one. A directed sequence builds both boot maps and probes the edges of every window, including the first byte past each window's end. A random phase then programs random bases, sizes and flags into all four words, so overlaps of every depth occur. It aims half of its addresses near the programmed bases and compares every result against a model that applies the priority rule.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  parameter int ADDR_W     = 17;
  parameter int CFG_W      = 16;
  parameter int NREG       = 4;
  parameter int PAGE_LSB   = 10;
  parameter int MIN_SZ_LOG = 9;
  parameter int CODE_W     = 3;

  localparam int PAGE_W  = ADDR_W - PAGE_LSB;
  localparam int IDX_W   = $clog2(NREG);
  localparam int SHAMT_W = $clog2(ADDR_W + 1);

  // field positions in the packed configuration word
  localparam int F_PAGE_LSB = 0;
  localparam int F_CODE_LSB = 8;
  localparam int F_RO_BIT   = 12;
  localparam int F_EN_BIT   = 15;

  localparam int ROM_IDX = 0;

  typedef struct packed {
    logic              ro;
    logic [CODE_W-1:0] code;
    logic [PAGE_W-1:0] page;
  } region_cfg_t;
endpackage

// File: rtl/mdec_cfg_regs.sv
module mdec_cfg_regs
  import mdec_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [CFG_W-1:0]            wdata_i,
  output region_cfg_t [NREG-1:0]      cfg_o,
  output logic                        map_en_o
);
  region_cfg_t [NREG-1:0] cfg_q;
  logic                   map_en_q;

  region_cfg_t wr_cfg;
  always_comb begin
    wr_cfg.ro   = wdata_i[F_RO_BIT];
    wr_cfg.code = wdata_i[F_CODE_LSB +: CODE_W];
    wr_cfg.page = wdata_i[F_PAGE_LSB +: PAGE_W];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cfg_q[r] <= '0;
      else if (we_i && (idx_i == IDX_W'(r)))         cfg_q[r] <= wr_cfg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     map_en_q <= 1'b0;
    else if (we_i && (idx_i == IDX_W'(ROM_IDX)))     map_en_q <= wdata_i[F_EN_BIT];
  end

  assign cfg_o    = cfg_q;
  assign map_en_o = map_en_q;
endmodule

// File: rtl/mdec_region_match.sv
module mdec_region_match
  import mdec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  region_cfg_t       cfg_i,
  output logic              hit_o
);
  logic [SHAMT_W-1:0] shamt;
  logic [ADDR_W-1:0]  keep_mask;
  logic [ADDR_W-1:0]  base;

  always_comb begin
    shamt     = SHAMT_W'(MIN_SZ_LOG) + SHAMT_W'(cfg_i.code);
    keep_mask = ~(({{(ADDR_W-1){1'b0}}, 1'b1} << shamt) - {{(ADDR_W-1){1'b0}}, 1'b1});
    base      = {cfg_i.page, {PAGE_LSB{1'b0}}};
    hit_o     = ((addr_i ^ base) & keep_mask) == '0;
  end
endmodule

// File: rtl/mdec_prio_pick.sv
module mdec_prio_pick
  import mdec_pkg::*;
(
  input  logic [NREG-1:0] hit_i,
  output logic [NREG-1:0] grant_o
);
  // highest index wins
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (hit_i[r] && !taken) begin
        grant_o[r] = 1'b1;
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_idx_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [16:0]       addr_i,
  output logic [3:0]        sel_o,
  output logic              miss_o,
  output logic              fault_o
);
  region_cfg_t [NREG-1:0] cfg;
  logic                   map_en;
  logic [NREG-1:0]        hit;
  logic [NREG-1:0]        grant;
  logic                   ro_hit;
  logic                   fault_q;

  mdec_cfg_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .idx_i    (cfg_idx_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg),
    .map_en_o (map_en)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_match
    mdec_region_match u_match (
      .addr_i (addr_i),
      .cfg_i  (cfg[r]),
      .hit_o  (hit[r])
    );
  end

  mdec_prio_pick u_prio (
    .hit_i   (hit),
    .grant_o (grant)
  );

  always_comb begin
    ro_hit = 1'b0;
    for (int r = 0; r < NREG; r++) ro_hit |= grant[r] & cfg[r].ro;
  end

  always_comb begin
    sel_o  = '0;
    miss_o = 1'b0;
    if (acc_valid_i) begin
      if (!map_en) sel_o[ROM_IDX] = 1'b1;
      else begin
        sel_o  = grant;
        miss_o = ~|grant;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= acc_valid_i & acc_we_i & map_en & ro_hit;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_valid_i,
  input logic       acc_we_i,
  input logic [3:0] sel_o,
  input logic       miss_o,
  input logic       fault_o,
  input logic       map_en
);
  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (sel_o == 4'b0000) && !miss_o);

  p_miss_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> ((sel_o != 4'b0000) != miss_o));

  p_disabled_rom_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !map_en) |-> (sel_o == 4'b0001));

  p_fault_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_we_i && map_en && sel_o == 4'b0000) |=> !fault_o);

  p_no_read_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i || !acc_we_i || miss_o) |=> !fault_o);
endmodule

bind mem_region_decoder mdec_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_we_i    (acc_we_i),
  .sel_o       (sel_o),
  .miss_o      (miss_o),
  .fault_o     (fault_o),
  .map_en      (map_en)
);

// File: tb/mem_region_decoder_tb_top.sv
module mem_region_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic [16:0] addr = '0;
  logic [3:0]  sel;
  logic        miss;
  logic        fault;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] sh [4];

  always #5 clk = ~clk;

  mem_region_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .acc_valid_i(acc_valid), .acc_we_i(acc_we),
    .addr_i(addr), .sel_o(sel), .miss_o(miss), .fault_o(fault)
  );

  function automatic logic [15:0] pack(input logic [6:0] page, input logic [2:0] code,
                                       input logic ro, input logic en);
    return {en, 2'b00, ro, 1'b0, code, 1'b0, page};
  endfunction

  function automatic logic hit_of(input int r, input logic [16:0] a);
    int s;
    logic [16:0] b;
    s = 9 + int'(sh[r][10:8]);
    b = {sh[r][6:0], 10'b0};
    return (a >> s) == (b >> s);
  endfunction

  function automatic logic [3:0] exp_sel(input logic [16:0] a);
    if (!sh[0][15]) return 4'b0001;
    for (int r = 3; r >= 0; r--) if (hit_of(r, a)) return 4'(1 << r);
    return 4'b0000;
  endfunction

  function automatic logic exp_fault(input logic [16:0] a, input logic we);
    logic [3:0] s;
    s = exp_sel(a);
    if (!sh[0][15] || !we) return 1'b0;
    for (int r = 0; r < 4; r++) if (s[r]) return sh[r][12];
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] idx, input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 2'd0) sh[0] = w;
    else sh[idx] = w;
  endtask

  task automatic access(input logic [16:0] a, input logic we, input string sel_tag,
                        input string flt_tag);
    logic [3:0] es;
    logic       ef;
    es = exp_sel(a);
    ef = exp_fault(a, we);
    @(negedge clk);
    addr = a; acc_we = we; acc_valid = 1'b1;
    #1;
    check({sel_tag, " sel"}, 32'(sel), 32'(es));
    check("R5 miss", 32'(miss), 32'(sh[0][15] && es == 4'b0000));
    @(posedge clk);
    #1;
    acc_valid = 1'b0; acc_we = 1'b0;
    check({flt_tag, " fault"}, 32'(fault), 32'(ef));
    @(posedge clk);
    #1;
    check("R6 pulse width", 32'(fault), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 4; r++) sh[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state, map off
    #1;
    check("R8 idle sel", 32'(sel), 32'd0);
    check("R8 idle miss", 32'(miss), 32'd0);
    check("R1 reset fault", 32'(fault), 32'd0);
    access(17'h01234, 1'b1, "R1", "R1");
    access(17'h1ffff, 1'b0, "R1", "R1");

    // R9: enable bit in another region's word has no effect
    wr_cfg(2'd1, pack(7'h40, 3'd6, 1'b1, 1'b1));
    access(17'h10000, 1'b1, "R9", "R9");

    // boot map: flash 32K at 0x10000, dflash 2K at 0x18800, RAM 4K at 0x19000
    wr_cfg(2'd1, pack(7'h40, 3'd6, 1'b0, 1'b0));
    wr_cfg(2'd2, pack(7'h62, 3'd2, 1'b0, 1'b0));
    wr_cfg(2'd3, pack(7'h64, 3'd3, 1'b0, 1'b0));
    access(17'h10000, 1'b0, "R1", "R1");
    wr_cfg(2'd0, pack(7'h00, 3'd7, 1'b1, 1'b1));
    // R3: new word visible the cycle right after the write
    access(17'h00000, 1'b1, "R3", "R6");
    access(17'h0a000, 1'b0, "R4", "R7");
    access(17'h10004, 1'b1, "R4", "R7");
    access(17'h17fff, 1'b0, "R2", "R7");
    access(17'h18000, 1'b0, "R5", "R7");
    access(17'h18800, 1'b1, "R2", "R7");
    access(17'h18fff, 1'b1, "R2", "R7");
    access(17'h19000, 1'b1, "R4", "R7");
    access(17'h19fff, 1'b0, "R2", "R7");
    access(17'h1a000, 1'b1, "R5", "R7");
    access(17'h0ffff, 1'b1, "R2", "R6");

    // run map: ROM 4K at 0xA000, flash 32K at 0
    wr_cfg(2'd0, pack(7'h28, 3'd3, 1'b1, 1'b1));
    wr_cfg(2'd1, pack(7'h00, 3'd6, 1'b0, 1'b0));
    access(17'h00000, 1'b1, "R2", "R7");
    access(17'h07fff, 1'b0, "R2", "R7");
    access(17'h08000, 1'b1, "R5", "R7");
    access(17'h0a000, 1'b1, "R2", "R6");
    access(17'h0afff, 1'b0, "R2", "R7");
    access(17'h0b000, 1'b0, "R5", "R7");

    // R4: full overlap stack, RAM wins everywhere it sits
    wr_cfg(2'd2, pack(7'h64, 3'd4, 1'b1, 1'b0));
    access(17'h19000, 1'b1, "R4", "R7");
    access(17'h1b000, 1'b1, "R4", "R6");

    // map off again restores ROM-only decoding
    wr_cfg(2'd0, pack(7'h28, 3'd3, 1'b1, 1'b0));
    access(17'h0a000, 1'b1, "R1", "R1");

    // random phase
    for (int k = 0; k < 40; k++) begin
      for (int r = 3; r >= 0; r--) begin
        logic en;
        en = ($urandom % 5) != 0;
        wr_cfg(2'(r), pack(7'($urandom), 3'($urandom), 1'($urandom), (r == 0) ? en : 1'($urandom)));
      end
      for (int j = 0; j < 20; j++) begin
        logic [16:0] a;
        if ($urandom % 2) a = {sh[$urandom % 4][6:0], 10'b0} + 17'($urandom % 4096) - 17'd1024;
        else              a = 17'($urandom);
        access(a, 1'($urandom), "R4", "R6");
      end
      @(negedge clk);
      #1;
      check("R8 idle sel", 32'(sel), 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule